// File: doc/BRIEF.md
# DCC Packet Half-Bit Receiver

This block sits behind a pulse-width classifier on a model-railway DCC track input. Each cycle it may receive one half-bit symbol: a strobe together with a value that is 1 for a short half cycle and 0 for a long half cycle. From that symbol stream it finds the preamble, waits for the start bit, checks that the two halves of every bit agree, and shifts each data bit into a byte. It then reports every finished byte, signals the end of the packet and reports whether the packet checksum holds.

A single down-counter does two jobs. While the block hunts for the preamble it counts the remaining "1" halves. Inside a byte it counts the remaining data bits. When the two halves of a bit disagree, the block drops the packet and hunts for a fresh preamble. The checksum is a running XOR of all bytes in the packet, the final error byte included. A packet passes when that XOR is zero and it holds at least two bytes.

Top module: `dcc_half_bit_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `byte_vld`, `eom` and `csum_ok` are 0. The block then hunts for the preamble with a fresh count of 20.
- R2: A preamble is 20 consecutive "1" halves. A "0" half before the count is complete restarts the count. With 19 ones, or with a run broken by a "0", a following packet produces no byte and no `eom`.
- R3: Cycles with `half_stb` low have no effect, whatever `half_val` carries. Idle cycles inside a preamble or a packet change neither the bytes nor the result.
- R4: Data bits are shifted in MSB first. Each finished byte appears on `byte_data`, with `byte_vld` high for exactly one cycle. That cycle is the cycle after the strobe of the second half of the byte's eighth bit.
- R5: After the preamble count is complete, further "1" halves before the first "0" half are ignored. A longer preamble therefore still works.
- R6: When the second half of a bit differs from the first half, the packet is dropped and the block hunts for the preamble again. This applies to the start bit and to data bits. Symbols after that point produce no byte until a new preamble of 20 "1" halves has been seen.
- R7: After a byte, a "0" half starts another byte. A "1" half ends the packet: `eom` is high for exactly one cycle, the cycle after that strobe. Every byte of a multi-byte packet is reported in order.
- R8: `csum_ok` is updated only in the cycle in which `eom` is high, and holds its value until the next `eom`. It is 1 when the XOR of all bytes of the packet is zero and the packet has at least two bytes.
- R9: A packet whose byte XOR is non-zero gives `csum_ok` = 0.
- R10: A packet with a single byte gives `eom` with `csum_ok` = 0, even when that byte is 0x00.
- R11: After `eom` the block hunts for the preamble again. A packet sent with no preamble produces no byte and no `eom`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_stb | input | 1 | A half-bit symbol is present this cycle |
| half_val | input | 1 | Symbol value: 1 = short half, 0 = long half |
| byte_data | output | BYTE_W (8) | Last completed byte, MSB received first |
| byte_vld | output | 1 | One-cycle pulse: `byte_data` holds a new byte |
| eom | output | 1 | One-cycle pulse: the packet end bit was received |
| csum_ok | output | 1 | Checksum verdict of the last packet, held until the next `eom` |

## Verification
All three results are registered. `byte_vld` rises in the cycle that directly follows the strobe of the final half of a byte's last bit. `eom` and the new `csum_ok` level appear in the cycle that directly follows the strobe of the end-bit half. The bench drives each strobe on a falling edge and returns at the next falling edge, so it samples those outputs exactly in the cycle in which they are due. One falling edge later it confirms that each pulse has dropped again. Byte and packet counts are collected by a falling-edge monitor and compared only after a further settle delay, so the pulse timing and the totals are checked separately.

// File: rtl/dcc_rx_pkg.sv
package dcc_rx_pkg;

    localparam int DEF_PRE_LEN   = 20;
    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_MIN_BYTES = 2;

    typedef enum logic [2:0] {
        ST_HUNT       = 3'd0,
        ST_WAIT_START = 3'd1,
        ST_CHK_ZERO   = 3'd2,
        ST_FIRST_HALF = 3'd3,
        ST_CHK_ONE    = 3'd4,
        ST_END_OR_NXT = 3'd5
    } rx_state_e;

    // control strobes from the sequencer to the datapath
    typedef struct packed {
        logic pkt_start;
        logic shift_en;
        logic byte_done;
        logic pkt_end;
    } rx_ctl_t;

    // true when the current half closes a bit whose first half it matches
    function automatic logic half_matches(input rx_state_e st, input logic val);
        return (st == ST_CHK_ZERO && !val) || (st == ST_CHK_ONE && val);
    endfunction

    // true when the current half contradicts the first half of its bit
    function automatic logic half_conflicts(input rx_state_e st, input logic val);
        return (st == ST_CHK_ZERO && val) || (st == ST_CHK_ONE && !val);
    endfunction

endpackage

// File: rtl/dcc_rx_seq.sv
module dcc_rx_seq
    import dcc_rx_pkg::*;
#(
    parameter int PRE_LEN = DEF_PRE_LEN,
    parameter int BYTE_W  = DEF_BYTE_W,
    localparam int CNT_MAX = (PRE_LEN > BYTE_W) ? PRE_LEN : BYTE_W,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_stb,
    input  logic             half_val,
    output rx_state_e        st,
    output logic [CNT_W-1:0] cnt,
    output rx_ctl_t          ctl
);

    localparam logic [CNT_W-1:0] LOAD_PRE  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] LOAD_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    rx_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_dec;

    assign cnt_dec = cnt_q - ONE;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ctl   = '0;
        if (half_stb) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (half_val) begin
                        cnt_d = cnt_dec;
                        if (cnt_dec == '0) st_d = ST_WAIT_START;
                    end else begin
                        cnt_d = LOAD_PRE;
                    end
                end
                ST_WAIT_START: begin
                    if (!half_val) begin
                        cnt_d         = LOAD_BYTE;
                        st_d          = ST_CHK_ZERO;
                        ctl.pkt_start = 1'b1;
                    end
                end
                ST_CHK_ZERO, ST_CHK_ONE: begin
                    if (half_conflicts(st_q, half_val)) begin
                        cnt_d = LOAD_PRE;
                        st_d  = ST_HUNT;
                    end else if (half_matches(st_q, half_val)) begin
                        if (cnt_q == '0) begin
                            st_d          = ST_END_OR_NXT;
                            ctl.byte_done = 1'b1;
                        end else begin
                            st_d = ST_FIRST_HALF;
                        end
                    end
                end
                ST_FIRST_HALF: begin
                    ctl.shift_en = 1'b1;
                    cnt_d        = cnt_dec;
                    st_d         = half_val ? ST_CHK_ONE : ST_CHK_ZERO;
                end
                ST_END_OR_NXT: begin
                    if (!half_val) begin
                        cnt_d = LOAD_BYTE;
                        st_d  = ST_CHK_ZERO;
                    end else begin
                        cnt_d       = LOAD_PRE;
                        st_d        = ST_HUNT;
                        ctl.pkt_end = 1'b1;
                    end
                end
                default: begin
                    cnt_d = LOAD_PRE;
                    st_d  = ST_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_HUNT;
            cnt_q <= LOAD_PRE;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign st  = st_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/dcc_rx_shift.sv
module dcc_rx_shift
    import dcc_rx_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_val,
    input  rx_ctl_t           ctl,
    output logic [BYTE_W-1:0] sh_cur,
    output logic [BYTE_W-1:0] byte_q,
    output logic              vld_q
);

    logic [BYTE_W-1:0] sh_q;

    // MSB first: older bits move towards the top
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (ctl.shift_en) begin
            sh_q <= {sh_q[BYTE_W-2:0], half_val};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= ctl.byte_done;
            if (ctl.byte_done) byte_q <= sh_q;
        end
    end

    assign sh_cur = sh_q;

endmodule

// File: rtl/dcc_rx_csum.sv
module dcc_rx_csum
    import dcc_rx_pkg::*;
#(
    parameter int BYTE_W    = DEF_BYTE_W,
    parameter int MIN_BYTES = DEF_MIN_BYTES,
    localparam int NB_W     = $clog2(MIN_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_ctl_t           ctl,
    input  logic [BYTE_W-1:0] sh_cur,
    output logic              eom_q,
    output logic              ok_q
);

    localparam logic [NB_W-1:0] NB_SAT = NB_W'(MIN_BYTES);

    logic [BYTE_W-1:0] acc_q;
    logic [NB_W-1:0]   nb_q;
    logic              verdict;

    assign verdict = (acc_q == '0) && (nb_q >= NB_SAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            nb_q  <= '0;
        end else if (ctl.pkt_start) begin
            acc_q <= '0;
            nb_q  <= '0;
        end else if (ctl.byte_done) begin
            acc_q <= acc_q ^ sh_cur;
            if (nb_q < NB_SAT) nb_q <= nb_q + NB_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eom_q <= 1'b0;
            ok_q  <= 1'b0;
        end else begin
            eom_q <= ctl.pkt_end;
            if (ctl.pkt_end) ok_q <= verdict;
        end
    end

endmodule

// File: rtl/dcc_half_bit_rx.sv
module dcc_half_bit_rx
    import dcc_rx_pkg::*;
#(
    parameter int PRE_LEN   = DEF_PRE_LEN,
    parameter int BYTE_W    = DEF_BYTE_W,
    parameter int MIN_BYTES = DEF_MIN_BYTES,
    localparam int CNT_MAX  = (PRE_LEN > BYTE_W) ? PRE_LEN : BYTE_W,
    localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_stb,
    input  logic              half_val,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld,
    output logic              eom,
    output logic              csum_ok
);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    rx_ctl_t           ctl;
    logic [BYTE_W-1:0] sh_cur;

    dcc_rx_seq #(
        .PRE_LEN (PRE_LEN),
        .BYTE_W  (BYTE_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .half_stb (half_stb),
        .half_val (half_val),
        .st       (st),
        .cnt      (cnt),
        .ctl      (ctl)
    );

    dcc_rx_shift #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .half_val (half_val),
        .ctl      (ctl),
        .sh_cur   (sh_cur),
        .byte_q   (byte_data),
        .vld_q    (byte_vld)
    );

    dcc_rx_csum #(
        .BYTE_W    (BYTE_W),
        .MIN_BYTES (MIN_BYTES)
    ) u_csum (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .sh_cur (sh_cur),
        .eom_q  (eom),
        .ok_q   (csum_ok)
    );

endmodule

// File: rtl/dcc_rx_chk.sv
module dcc_rx_chk
    import dcc_rx_pkg::*;
#(
    parameter int PRE_LEN = DEF_PRE_LEN,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             half_stb,
    input logic             half_val,
    input logic             byte_vld,
    input logic             eom,
    input logic             csum_ok,
    input rx_state_e        st,
    input logic [CNT_W-1:0] cnt
);

    // R1: outputs are clear right after a reset cycle
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!byte_vld && !eom && !csum_ok));

    // R2: the shared counter never exceeds the preamble load
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PRE_LEN));

    // R3: an idle cycle leaves the sequencer untouched and raises no pulse
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !half_stb |=> ($stable(st) && $stable(cnt) && !byte_vld && !eom));

    // R4: byte valid is a single-cycle pulse
    p_vld_single_r4: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R6: a disagreeing second half sends the block back to preamble hunting
    p_mismatch_resync_r6: assert property (@(posedge clk) disable iff (rst)
        (half_stb && ((st == ST_CHK_ZERO && half_val) || (st == ST_CHK_ONE && !half_val)))
        |=> (st == ST_HUNT && cnt == CNT_W'(PRE_LEN)));

    // R7: end of message is a single-cycle pulse and never coincides with a byte
    p_eom_single_r7: assert property (@(posedge clk) disable iff (rst)
        eom |=> !eom);
    p_eom_no_byte_r7: assert property (@(posedge clk) disable iff (rst)
        !(eom && byte_vld));

    // R8: the checksum verdict only moves together with end of message
    p_csum_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !eom |-> $stable(csum_ok));

    // R11: after end of message the block is hunting for a preamble
    p_hunt_after_eom_r11: assert property (@(posedge clk) disable iff (rst)
        eom |-> (st == ST_HUNT));

endmodule

bind dcc_half_bit_rx dcc_rx_chk #(
    .PRE_LEN (PRE_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .half_stb (half_stb),
    .half_val (half_val),
    .byte_vld (byte_vld),
    .eom      (eom),
    .csum_ok  (csum_ok),
    .st       (st),
    .cnt      (cnt)
);

// File: tb/dcc_half_bit_rx_tb.sv
module dcc_half_bit_rx_tb;

    localparam int CLK_P = 10;
    localparam int NV    = 6;

    localparam int V_PRE [NV] = '{20, 20, 20, 25, 20, 30};
    localparam int V_N   [NV] = '{3, 3, 2, 4, 1, 2};
    localparam int V_GAP [NV] = '{0, 1, 2, 0, 1, 2};
    localparam logic [7:0] V_B [NV][4] = '{
        '{8'hA5, 8'h3C, 8'h99, 8'h00},
        '{8'h01, 8'h02, 8'h04, 8'h00},
        '{8'hFF, 8'hFF, 8'h00, 8'h00},
        '{8'h12, 8'h34, 8'h56, 8'h70},
        '{8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h80, 8'h80, 8'h00, 8'h00}
    };
    localparam logic V_OK [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_stb = 1'b0;
    logic       half_val = 1'b0;
    logic [7:0] byte_data;
    logic       byte_vld;
    logic       eom;
    logic       csum_ok;

    int total = 0;
    int bad   = 0;
    int ncap  = 0;
    int neom  = 0;
    bit done  = 1'b0;
    logic [7:0] cap [64];

    always #(CLK_P/2) clk = ~clk;

    dcc_half_bit_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .half_stb  (half_stb),
        .half_val  (half_val),
        .byte_data (byte_data),
        .byte_vld  (byte_vld),
        .eom       (eom),
        .csum_ok   (csum_ok)
    );

    // falling-edge monitor of pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld && ncap < 64) begin
                cap[ncap] = byte_data;
                ncap++;
            end
            if (eom) neom++;
        end
    end

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        half_stb = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            half_stb = 1'b0;
            half_val = i[0];
            @(negedge clk);
        end
    endtask

    task automatic half(input logic v, input int gap);
        idle(gap);
        half_stb = 1'b1;
        half_val = v;
        @(negedge clk);
        half_stb = 1'b0;
    endtask

    task automatic bitv(input logic v, input int gap);
        half(v, gap);
        half(v, gap);
    endtask

    task automatic ones(input int n, input int gap);
        for (int i = 0; i < n; i++) half(1'b1, gap);
    endtask

    task automatic byte_tx(input logic [7:0] b, input int gap);
        bitv(1'b0, gap);
        for (int i = 7; i >= 0; i--) bitv(b[i], gap);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int nb0;
        int ne0;
        logic prev_ok;

        // R1: reset state
        @(negedge clk);
        chk(!byte_vld && !eom && !csum_ok, "R1 during reset", {byte_vld, eom, csum_ok}, 0);
        do_reset();
        chk(!byte_vld && !eom && !csum_ok, "R1 after reset", {byte_vld, eom, csum_ok}, 0);

        // R4: timing and MSB-first order of one byte
        ones(20, 0);
        bitv(1'b0, 0);
        for (int i = 7; i >= 1; i--) bitv(8'hC3 >> i & 8'h01, 0);
        half(1'b1, 0);
        chk(!byte_vld, "R4 no early valid", byte_vld, 0);
        half(1'b1, 0);
        chk(byte_vld, "R4 valid due", byte_vld, 1);
        chk(byte_data == 8'hC3, "R4 byte MSB first", byte_data, 8'hC3);
        @(negedge clk);
        chk(!byte_vld, "R4 valid one cycle", byte_vld, 0);
        half(1'b1, 0);
        chk(eom && !csum_ok, "R10 single byte eom", {eom, csum_ok}, 2'b10);

        // vector table walk (R5, R7, R8, R9, R10)
        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = (k == 1) ? "R9" : (k == 4) ? "R10" : (k == 5) ? "R5" : "R8";
            settle();
            nb0 = ncap;
            ne0 = neom;
            prev_ok = csum_ok;
            ones(V_PRE[k], V_GAP[k]);
            for (int j = 0; j < V_N[k]; j++) byte_tx(V_B[k][j], V_GAP[k]);
            idle(3);
            chk(csum_ok == prev_ok, "R8 verdict held", csum_ok, prev_ok);
            half(1'b1, V_GAP[k]);
            chk(eom == 1'b1, "R7 eom due", eom, 1);
            chk(csum_ok == V_OK[k], tag, csum_ok, V_OK[k]);
            @(negedge clk);
            chk(eom == 1'b0, "R7 eom one cycle", eom, 0);
            #1;
            chk(ncap - nb0 == V_N[k], "R7 byte count", ncap - nb0, V_N[k]);
            chk(neom - ne0 == 1, "R7 eom count", neom - ne0, 1);
            for (int j = 0; j < V_N[k]; j++)
                if (nb0 + j < 64)
                    chk(cap[nb0 + j] == V_B[k][j], "R7 byte order", cap[nb0 + j], V_B[k][j]);
        end

        // R11: no preamble after eom
        settle();
        nb0 = ncap;
        ne0 = neom;
        byte_tx(8'h55, 0);
        byte_tx(8'h55, 0);
        half(1'b1, 0);
        settle();
        chk(ncap == nb0 && neom == ne0, "R11 no preamble ignored", ncap - nb0, 0);

        // R2: short and broken preambles
        do_reset();
        nb0 = ncap;
        ne0 = neom;
        ones(19, 0);
        byte_tx(8'h55, 0);
        half(1'b1, 0);
        ones(15, 0);
        half(1'b0, 0);
        ones(10, 0);
        byte_tx(8'h55, 0);
        half(1'b1, 0);
        settle();
        chk(ncap == nb0 && neom == ne0, "R2 short preamble", ncap - nb0, 0);
        ones(20, 0);
        byte_tx(8'h55, 0);
        half(1'b1, 0);
        settle();
        chk(ncap == nb0 + 1 && neom == ne0 + 1, "R2 full preamble", ncap - nb0, 1);

        // R3: idle cycles inside preamble and packet
        nb0 = ncap;
        ones(10, 0);
        idle(5);
        ones(10, 0);
        byte_tx(8'h5A, 3);
        byte_tx(8'h5A, 1);
        half(1'b1, 4);
        chk(eom && csum_ok, "R3 idle ignored verdict", {eom, csum_ok}, 2'b11);
        settle();
        chk(ncap == nb0 + 2, "R3 idle ignored bytes", ncap - nb0, 2);

        // R6: mismatched halves in a data bit and in the start bit
        nb0 = ncap;
        ne0 = neom;
        ones(20, 0);
        bitv(1'b0, 0);
        half(1'b1, 0);
        half(1'b0, 0);
        for (int i = 0; i < 7; i++) bitv(1'b0, 0);
        byte_tx(8'h55, 0);
        half(1'b1, 0);
        ones(20, 0);
        half(1'b0, 0);
        half(1'b1, 0);
        byte_tx(8'hAA, 0);
        half(1'b1, 0);
        settle();
        chk(ncap == nb0 && neom == ne0, "R6 mismatch drops packet", ncap - nb0, 0);
        ones(20, 0);
        byte_tx(8'h3C, 0);
        byte_tx(8'h3C, 0);
        half(1'b1, 0);
        chk(eom && csum_ok, "R6 recovery after preamble", {eom, csum_ok}, 2'b11);

        finish_run();
    end

endmodule